// File: doc/BRIEF.md
# Halfword-Precise Instruction and Data Breakpoint Unit

This block watches a processor's instruction-fetch and data-access traffic. When an access hits a programmed break address it requests a breakpoint exception, together with the program-counter value the exception must save. Each fetch word is 32 bits and holds two 16-bit instructions. The unit notes which halfword of a fetched word matched. It raises the request only when that instruction reaches the execute stage, so a hit on the second halfword fires only after the first instruction has run.

An ordinary instruction hit is precise. The break is requested before the instruction executes, and the saved PC is the instruction's own address. Two cases are deferred instead: a hit on an instruction in a delayed-branch slot, and a hit on an instruction that follows an interrupt-blocking one. In both, the hit is parked in a single-entry latch. It is released by the first later retire strobe flagged as able to accept an interrupt, and the saved PC is the address of the next instruction to execute. Data-access hits are imprecise and use the same latch and release rule.

The request leaves on a valid/ready pair. It stays valid, with a stable PC, until the exception logic takes it. While a request is parked or presented, new hits raise no further request. A sticky status flag records every hit, and software clears it through a strobe.

Top module: `brk_unit`

## Requirements
- R1: Fetch comparison works per halfword. Halfword h (0 = low, 1 = high) of fetched word W has address {W, h, 0}. It matches when it equals `cfg_addr` on every bit not set in `cfg_mask`, with address bit 0 always ignored. Data comparison uses the same rule on `dacc_addr`.
- R2: A matched halfword with neither slot flag set raises `brk_valid` one cycle after the `ex_valid` cycle that presents its address, with `brk_pc` equal to that address. A match on the high halfword does not fire while the low halfword executes.
- R3: If the matched instruction has `ex_dslot` or `ex_post_inhibit` set, nothing fires at execute. `brk_valid` rises one cycle after the first later cycle with `ret_valid` and `ret_accept` both 1, with `brk_pc` equal to that cycle's `ret_next_pc`.
- R4: A data access hits only when `cfg_dacc` is 1, `dacc_write` (1 = write) is allowed by `cfg_wr`/`cfg_rd`, and `dacc_periph` (1 = peripheral master) is allowed by `cfg_per`/`cfg_cpu`. A hit is released like R3.
- R5: With `cfg_ifetch` at 0, no fetch hit is recorded and no instruction break fires.
- R6: At most one break is outstanding, counting parked and presented breaks together. Hits that arrive while one is outstanding raise no request.
- R7: When a precise instruction hit and a data hit fall in the same cycle with nothing outstanding, the instruction break is presented and the data hit is dropped.
- R8: While `brk_valid` is 1 and `brk_ready` is 0, `brk_valid` and `brk_pc` hold. After a cycle with both at 1, `brk_valid` is 0.
- R9: `stat_hit` becomes 1 the cycle after any instruction or data hit, including hits dropped under R6 or R7. It becomes 0 the cycle after `stat_clr`, but a hit in the same cycle wins.
- R10: After reset `brk_valid` and `stat_hit` are 0 and no halfword is recorded.
- R11: A recorded halfword is consumed when its address is executed. Executing it again without a new matching fetch does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | AW | Break address |
| cfg_mask | input | AW | Address bits to ignore (1 = don't care) |
| cfg_ifetch | input | 1 | Enable instruction-fetch breaks |
| cfg_dacc | input | 1 | Enable data-access breaks |
| cfg_rd | input | 1 | Data reads may hit |
| cfg_wr | input | 1 | Data writes may hit |
| cfg_cpu | input | 1 | CPU-mastered accesses may hit |
| cfg_per | input | 1 | Peripheral-mastered accesses may hit |
| fetch_valid | input | 1 | A 32-bit fetch completes this cycle |
| fetch_word | input | AW-2 | Word address of the fetch |
| ex_valid | input | 1 | An instruction enters execute this cycle |
| ex_pc | input | AW | Address of that instruction |
| ex_dslot | input | 1 | The instruction sits in a delayed-branch slot |
| ex_post_inhibit | input | 1 | The instruction follows an interrupt-blocking one |
| ret_valid | input | 1 | One-cycle retire strobe |
| ret_accept | input | 1 | An interrupt may be taken after the retiring instruction |
| ret_next_pc | input | AW | Address of the next instruction to execute |
| dacc_valid | input | 1 | A data access occurs this cycle |
| dacc_addr | input | AW | Data access address |
| dacc_write | input | 1 | 1 = write, 0 = read |
| dacc_periph | input | 1 | 1 = peripheral master, 0 = CPU |
| brk_valid | output | 1 | Break request |
| brk_ready | input | 1 | Exception logic takes the request |
| brk_pc | output | AW | PC to save for the break |
| stat_hit | output | 1 | Sticky hit status |
| stat_clr | input | 1 | Clear strobe for the status |

## Verification
Two collisions can fall in the same cycle. One is a precise instruction hit arriving together with a matching data access. The other is a retire strobe that releases a parked break while a new execute-stage hit arrives. The bench provokes the first directly, with an armed halfword executing as a matching write goes by. It then checks that the presented PC is the instruction's address and that no second request follows the next accepting retire. Random traffic produces both collisions many times over. A cycle-level model built from the requirements judges `brk_valid`, `brk_pc` and `stat_hit` on every cycle.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef struct packed {
    logic ifetch;
    logic dacc;
    logic rd;
    logic wr;
    logic cpu;
    logic per;
  } brk_cond_t;
endpackage

// File: rtl/brk_cmp.sv
module brk_cmp #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] mask,
  output logic          hit
);
  // bit 0 never takes part: everything is halfword granular
  localparam logic [AW-1:0] CARE = ~AW'(1);
  assign hit = (((addr ^ ref_addr) & ~mask & CARE) == '0);
endmodule

// File: rtl/brk_fetch_track.sv
module brk_fetch_track #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] cfg_addr,
  input  logic [AW-1:0] cfg_mask,
  input  logic          fetch_valid,
  input  logic [AW-3:0] fetch_word,
  input  logic          ex_valid,
  input  logic [AW-2:0] ex_hw,
  output logic          ex_hit
);
  localparam int HALVES = 2;

  logic [AW-3:0]     word_q;
  logic [HALVES-1:0] arm_q;
  logic [HALVES-1:0] fm;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic hw_hit;
    brk_cmp #(.AW(AW)) u_cmp (
      .addr     ({fetch_word, 1'(h), 1'b0}),
      .ref_addr (cfg_addr),
      .mask     (cfg_mask),
      .hit      (hw_hit)
    );
    assign fm[h] = fetch_valid & en & hw_hit;
  end

  logic same_word;
  assign same_word = (ex_hw[AW-2:1] == word_q);
  assign ex_hit    = ex_valid & en & same_word & arm_q[ex_hw[0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      arm_q  <= '0;
    end else if (|fm) begin
      word_q <= fetch_word;
      arm_q  <= fm;
    end else if (ex_valid && same_word) begin
      arm_q[ex_hw[0]] <= 1'b0;
    end
  end
endmodule

// File: rtl/brk_data_match.sv
module brk_data_match
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  brk_cond_t     cond,
  input  logic [AW-1:0] cfg_addr,
  input  logic [AW-1:0] cfg_mask,
  input  logic          dacc_valid,
  input  logic [AW-1:0] dacc_addr,
  input  logic          dacc_write,
  input  logic          dacc_periph,
  output logic          d_hit
);
  logic a_hit, dir_ok, mst_ok;

  brk_cmp #(.AW(AW)) u_cmp (
    .addr     (dacc_addr),
    .ref_addr (cfg_addr),
    .mask     (cfg_mask),
    .hit      (a_hit)
  );

  assign dir_ok = dacc_write  ? cond.wr  : cond.rd;
  assign mst_ok = dacc_periph ? cond.per : cond.cpu;
  assign d_hit  = dacc_valid & cond.dacc & a_hit & dir_ok & mst_ok;
endmodule

// File: rtl/brk_pend.sv
module brk_pend #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          imm_hit,
  input  logic          def_hit,
  input  logic          d_hit,
  input  logic [AW-1:0] ex_pc,
  input  logic          ret_valid,
  input  logic          ret_accept,
  input  logic [AW-1:0] ret_next_pc,
  input  logic          brk_ready,
  output logic          brk_valid,
  output logic [AW-1:0] brk_pc
);
  logic pend_q;
  logic busy;
  assign busy = pend_q | brk_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      brk_valid <= 1'b0;
      brk_pc    <= '0;
    end else begin
      if (brk_valid && brk_ready) brk_valid <= 1'b0;
      if (!busy) begin
        if (imm_hit) begin
          brk_valid <= 1'b1;
          brk_pc    <= ex_pc;
        end else if (def_hit || d_hit) begin
          pend_q <= 1'b1;
        end
      end else if (pend_q && ret_valid && ret_accept) begin
        pend_q    <= 1'b0;
        brk_valid <= 1'b1;
        brk_pc    <= ret_next_pc;
      end
    end
  end
endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] cfg_addr,
  input  logic [AW-1:0] cfg_mask,
  input  logic          cfg_ifetch,
  input  logic          cfg_dacc,
  input  logic          cfg_rd,
  input  logic          cfg_wr,
  input  logic          cfg_cpu,
  input  logic          cfg_per,
  input  logic          fetch_valid,
  input  logic [AW-3:0] fetch_word,
  input  logic          ex_valid,
  input  logic [AW-1:0] ex_pc,
  input  logic          ex_dslot,
  input  logic          ex_post_inhibit,
  input  logic          ret_valid,
  input  logic          ret_accept,
  input  logic [AW-1:0] ret_next_pc,
  input  logic          dacc_valid,
  input  logic [AW-1:0] dacc_addr,
  input  logic          dacc_write,
  input  logic          dacc_periph,
  output logic          brk_valid,
  input  logic          brk_ready,
  output logic [AW-1:0] brk_pc,
  output logic          stat_hit,
  input  logic          stat_clr
);
  brk_cond_t cond;
  assign cond = '{ifetch: cfg_ifetch, dacc: cfg_dacc, rd: cfg_rd,
                  wr: cfg_wr, cpu: cfg_cpu, per: cfg_per};

  logic i_hit, d_hit, defer;

  brk_fetch_track #(.AW(AW)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (cond.ifetch),
    .cfg_addr    (cfg_addr),
    .cfg_mask    (cfg_mask),
    .fetch_valid (fetch_valid),
    .fetch_word  (fetch_word),
    .ex_valid    (ex_valid),
    .ex_hw       (ex_pc[AW-1:1]),
    .ex_hit      (i_hit)
  );

  brk_data_match #(.AW(AW)) u_data (
    .cond        (cond),
    .cfg_addr    (cfg_addr),
    .cfg_mask    (cfg_mask),
    .dacc_valid  (dacc_valid),
    .dacc_addr   (dacc_addr),
    .dacc_write  (dacc_write),
    .dacc_periph (dacc_periph),
    .d_hit       (d_hit)
  );

  assign defer = ex_dslot | ex_post_inhibit;

  brk_pend #(.AW(AW)) u_pend (
    .clk         (clk),
    .rst_n       (rst_n),
    .imm_hit     (i_hit & ~defer),
    .def_hit     (i_hit & defer),
    .d_hit       (d_hit),
    .ex_pc       (ex_pc),
    .ret_valid   (ret_valid),
    .ret_accept  (ret_accept),
    .ret_next_pc (ret_next_pc),
    .brk_ready   (brk_ready),
    .brk_valid   (brk_valid),
    .brk_pc      (brk_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              stat_hit <= 1'b0;
    else if (i_hit || d_hit) stat_hit <= 1'b1;
    else if (stat_clr)       stat_hit <= 1'b0;
  end
endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ex_valid,
  input logic [AW-1:0] ex_pc,
  input logic          ret_valid,
  input logic          ret_accept,
  input logic [AW-1:0] ret_next_pc,
  input logic          dacc_valid,
  input logic          brk_valid,
  input logic          brk_ready,
  input logic [AW-1:0] brk_pc,
  input logic          pend_q,
  input logic          stat_hit
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_valid && !brk_ready |=> brk_valid && $stable(brk_pc));

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    brk_valid && brk_ready |=> !brk_valid);

  assert_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_valid) |-> $past(ex_valid) || $past(ret_valid && ret_accept));

  assert_exec_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_valid) && !$past(ret_valid) |-> brk_pc == $past(ex_pc));

  assert_defer_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_valid) && !$past(ex_valid) |-> brk_pc == $past(ret_next_pc));

  assert_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pend_q, brk_valid}));

  assert_stat_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_hit) |-> $past(ex_valid) || $past(dacc_valid));
endmodule

bind brk_unit brk_unit_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ex_valid    (ex_valid),
  .ex_pc       (ex_pc),
  .ret_valid   (ret_valid),
  .ret_accept  (ret_accept),
  .ret_next_pc (ret_next_pc),
  .dacc_valid  (dacc_valid),
  .brk_valid   (brk_valid),
  .brk_ready   (brk_ready),
  .brk_pc      (brk_pc),
  .pend_q      (u_pend.pend_q),
  .stat_hit    (stat_hit)
);

// File: tb/brk_unit_test.sv
module brk_unit_test;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [AW-1:0] cfg_addr = '0, cfg_mask = '0;
  logic cfg_ifetch = 0, cfg_dacc = 0, cfg_rd = 0, cfg_wr = 0, cfg_cpu = 0, cfg_per = 0;
  logic fetch_valid = 0; logic [AW-3:0] fetch_word = '0;
  logic ex_valid = 0, ex_dslot = 0, ex_post_inhibit = 0; logic [AW-1:0] ex_pc = '0;
  logic ret_valid = 0, ret_accept = 0; logic [AW-1:0] ret_next_pc = '0;
  logic dacc_valid = 0, dacc_write = 0, dacc_periph = 0; logic [AW-1:0] dacc_addr = '0;
  logic brk_ready = 0, stat_clr = 0;
  logic brk_valid, stat_hit; logic [AW-1:0] brk_pc;

  brk_unit #(.AW(AW)) uut (.*);

  int tests = 0, fails = 0;
  bit done = 0;

  // reference state
  logic m_arm0, m_arm1, m_pend, m_bv, m_stat;
  logic [AW-3:0] m_word;
  logic [AW-1:0] m_pc;

  function automatic bit amatch(input logic [AW-1:0] a);
    return (((a ^ cfg_addr) & ~cfg_mask & ~AW'(1)) == '0);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    fetch_valid = 0; ex_valid = 0; ex_dslot = 0; ex_post_inhibit = 0;
    ret_valid = 0; ret_accept = 0; dacc_valid = 0; stat_clr = 0; brk_ready = 0;
  endtask

  // one clock: model advances on the same inputs, outputs compared after the edge
  task automatic step();
    logic fm0, fm1, exh, dh, imm, dfr, busy;
    logic n_arm0, n_arm1, n_pend, n_bv, n_stat;
    logic [AW-3:0] n_word; logic [AW-1:0] n_pc;
    @(posedge clk);
    fm0 = fetch_valid && cfg_ifetch && amatch({fetch_word, 2'b00});
    fm1 = fetch_valid && cfg_ifetch && amatch({fetch_word, 2'b10});
    exh = ex_valid && cfg_ifetch && (ex_pc[AW-1:2] == m_word) && (ex_pc[1] ? m_arm1 : m_arm0);
    dh  = dacc_valid && cfg_dacc && amatch(dacc_addr) && (dacc_write ? cfg_wr : cfg_rd)
          && (dacc_periph ? cfg_per : cfg_cpu);
    imm = exh && !(ex_dslot || ex_post_inhibit);
    dfr = exh && (ex_dslot || ex_post_inhibit);
    busy = m_pend || m_bv;
    n_arm0 = m_arm0; n_arm1 = m_arm1; n_word = m_word;
    n_pend = m_pend; n_bv = m_bv; n_pc = m_pc; n_stat = m_stat;
    if (fm0 || fm1) begin n_word = fetch_word; n_arm0 = fm0; n_arm1 = fm1; end
    else if (ex_valid && ex_pc[AW-1:2] == m_word) begin
      if (ex_pc[1]) n_arm1 = 0; else n_arm0 = 0;
    end
    if (m_bv && brk_ready) n_bv = 0;
    if (!busy) begin
      if (imm) begin n_bv = 1; n_pc = ex_pc; end
      else if (dfr || dh) n_pend = 1;
    end else if (m_pend && ret_valid && ret_accept) begin
      n_pend = 0; n_bv = 1; n_pc = ret_next_pc;
    end
    if (exh || dh) n_stat = 1; else if (stat_clr) n_stat = 0;
    m_arm0 = n_arm0; m_arm1 = n_arm1; m_word = n_word; m_pend = n_pend;
    m_bv = n_bv; m_pc = n_pc; m_stat = n_stat;
    #1;
    chk("R2 R3 R4 R6 R8 model brk_valid", 64'(brk_valid), 64'(m_bv));
    if (m_bv) chk("R2 R3 R4 model brk_pc", 64'(brk_pc), 64'(m_pc));
    chk("R9 model stat_hit", 64'(stat_hit), 64'(m_stat));
    idle();
  endtask

  task automatic take();
    brk_ready = 1; step();
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0b7a));
    m_arm0 = 0; m_arm1 = 0; m_pend = 0; m_bv = 0; m_stat = 0; m_word = '0; m_pc = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk("R10 reset brk_valid", 64'(brk_valid), 0);
    chk("R10 reset stat_hit", 64'(stat_hit), 0);

    // R1 R2: low halfword, bit 0 of break address ignored
    cfg_ifetch = 1; cfg_addr = 32'h1001; cfg_mask = 0;
    fetch_valid = 1; fetch_word = 30'h400; step();
    ex_valid = 1; ex_pc = 32'h1000; step();
    chk("R2 low half fires", 64'(brk_valid), 1);
    chk("R1 R2 low half pc", 64'(brk_pc), 64'h1000);
    take();

    // R2: high halfword fires only at its own execute
    cfg_addr = 32'h1006;
    fetch_valid = 1; fetch_word = 30'h401; step();
    ex_valid = 1; ex_pc = 32'h1004; step();
    chk("R2 high half quiet on low exec", 64'(brk_valid), 0);
    ex_valid = 1; ex_pc = 32'h1006; step();
    chk("R2 high half pc", 64'(brk_pc), 64'h1006);
    take();

    // R11: re-execution without refetch
    ex_valid = 1; ex_pc = 32'h1006; step();
    chk("R11 consumed halfword", 64'(brk_valid), 0);

    // R3: delay slot deferral
    cfg_addr = 32'h1012;
    fetch_valid = 1; fetch_word = 30'h404; step();
    ex_valid = 1; ex_pc = 32'h1012; ex_dslot = 1; step();
    chk("R3 no fire in slot", 64'(brk_valid), 0);
    ret_valid = 1; ret_accept = 0; ret_next_pc = 32'h1014; step();
    chk("R3 waits for accepting retire", 64'(brk_valid), 0);
    ret_valid = 1; ret_accept = 1; ret_next_pc = 32'h2000; step();
    chk("R3 deferred pc", 64'(brk_pc), 64'h2000);
    chk("R3 deferred fires", 64'(brk_valid), 1);
    take();

    // R3: after interrupt-blocking instruction
    cfg_addr = 32'h1020;
    fetch_valid = 1; fetch_word = 30'h408; step();
    ex_valid = 1; ex_pc = 32'h1020; ex_post_inhibit = 1; step();
    ret_valid = 1; ret_accept = 1; ret_next_pc = 32'h1022; step();
    chk("R3 post-inhibit pc", 64'(brk_pc), 64'h1022);
    take();

    // R4: filters, then a hit
    cfg_ifetch = 0; cfg_dacc = 1; cfg_wr = 1; cfg_rd = 0; cfg_cpu = 1; cfg_per = 0;
    cfg_addr = 32'h8000;
    dacc_valid = 1; dacc_addr = 32'h8000; dacc_write = 0; step();
    dacc_valid = 1; dacc_addr = 32'h8000; dacc_write = 1; dacc_periph = 1; step();
    ret_valid = 1; ret_accept = 1; ret_next_pc = 32'h3000; step();
    chk("R4 filtered access no break", 64'(brk_valid), 0);
    dacc_valid = 1; dacc_addr = 32'h8000; dacc_write = 1; dacc_periph = 0; step();
    ret_valid = 1; ret_accept = 1; ret_next_pc = 32'h3002; step();
    chk("R4 data break pc", 64'(brk_pc), 64'h3002);
    take();

    // R5: fetch disabled
    cfg_dacc = 0; cfg_addr = 32'h1040;
    fetch_valid = 1; fetch_word = 30'h410; step();
    ex_valid = 1; ex_pc = 32'h1040; step();
    chk("R5 disabled no break", 64'(brk_valid), 0);

    // R1 mask, R7 collision, R8 hold
    cfg_ifetch = 1; cfg_dacc = 1; cfg_addr = 32'h1040; cfg_mask = 32'h10;
    fetch_valid = 1; fetch_word = 30'h414; step();
    ex_valid = 1; ex_pc = 32'h1050; dacc_valid = 1; dacc_addr = 32'h1040; dacc_write = 1; step();
    chk("R1 R7 instruction wins pc", 64'(brk_pc), 64'h1050);
    step(); step();
    chk("R8 held without ready", 64'(brk_valid), 1);
    take();
    ret_valid = 1; ret_accept = 1; ret_next_pc = 32'h1052; step();
    chk("R7 data hit dropped", 64'(brk_valid), 0);

    // R9: clear, and set beating clear
    stat_clr = 1; step();
    chk("R9 status cleared", 64'(stat_hit), 0);
    cfg_mask = 0;
    stat_clr = 1; dacc_valid = 1; dacc_addr = 32'h1040; dacc_write = 1; step();
    chk("R9 set wins over clear", 64'(stat_hit), 1);
    ret_valid = 1; ret_accept = 1; ret_next_pc = 32'h1060; step();
    take();

    // constrained random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) begin
        cfg_addr = 32'h100 | ($urandom & 32'h3E);
        cfg_mask = ($urandom % 4 == 0) ? 32'h4 : 32'h0;
        {cfg_ifetch, cfg_dacc, cfg_rd, cfg_wr, cfg_cpu, cfg_per} = 6'($urandom) | 6'b110000;
      end
      fetch_valid = ($urandom % 3 == 0);
      fetch_word = 30'h40 | 30'($urandom & 32'hF);
      ex_valid = ($urandom % 2 == 0);
      ex_pc = 32'h100 | ($urandom & 32'h3E);
      ex_dslot = ($urandom % 5 == 0);
      ex_post_inhibit = ($urandom % 6 == 0);
      ret_valid = ($urandom % 3 == 0);
      ret_accept = ($urandom % 4 != 0);
      ret_next_pc = $urandom & 32'hFFFE;
      dacc_valid = ($urandom % 4 == 0);
      dacc_addr = 32'h100 | ($urandom & 32'h3F);
      dacc_write = $urandom % 2; dacc_periph = $urandom % 2;
      brk_ready = ($urandom % 5 < 3);
      stat_clr = ($urandom % 8 == 0);
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule